// File: doc/BRIEF.md
# Step-Triggered Waveform Segment Sequencer

This block plays a programmed list of waveform segments out of an external sample memory, one list entry at a time. Each entry gives a segment base address, a segment length in samples, a repeat count and a marker offset. The first trigger starts entry 0. The entry's segment is played back to back for its repeat count, one sample per clock. The output then freezes on the segment's final sample, with the valid strobe still high, until the next trigger moves on to the following entry. Once the last active entry has finished, the next trigger starts the list again from entry 0.

Software fills the entry table through a simple write port and sets the number of active entries through a separate write strobe. The sample memory is outside the block. The block presents a read address, and the memory returns the addressed word in the same cycle (asynchronous read). The block registers that word onto the sample output, so each sample appears one clock after its address is driven. A marker output pulses with the sample that sits at the entry's marker offset, once on every pass through the segment.

The controller is a four-state machine:
- S_IDLE: reset state; waits for the first trigger.
- S_PLAY: streams samples.
- S_HOLD: holds the output between entries.
- S_DONE: holds the output after the last entry.

Its transitions are:
- IDLE→PLAY: a trigger arrives.
- PLAY→HOLD: the repeats of a non-final entry run out.
- PLAY→DONE: the repeats of the final entry run out.
- HOLD→PLAY: a trigger arrives; the next entry is loaded.
- DONE→PLAY: a trigger arrives; entry 0 is loaded.

Top module: `wave_step_seq`

## Requirements
- R1: After reset `smp_valid`, `marker` and `smp_out` are 0, and `smp_valid` stays 0 until the first trigger is accepted. Once it is high it never falls before the next reset.
- R2: A trigger sampled at clock edge k, while the block is not playing, loads an entry. At edge k+1+n the sample output shows the memory word at `base + (n mod L)` (address wrapping at 2^ADDR_W) for n = 0 … L·C−1, where L is the entry's length and C its repeat count.
- R3: A length field of 0 is played as a length of 1, and a repeat field of 0 is played as one pass.
- R4: After the final sample of an entry's last pass, `smp_out` keeps that sample and `smp_valid` stays 1 until a new trigger is accepted and the next segment begins.
- R5: A trigger accepted while holding after entry i starts entry i+1.
- R6: A trigger sampled at any edge while samples are still streaming has no effect and is not remembered.
- R7: The active entry count is written through `cnt_we`/`cnt_val`; 0 is taken as 1, values above MAX_STEPS are taken as MAX_STEPS, and the reset value is 1. When the final active entry finishes, the next trigger restarts at entry 0.
- R8: `marker` is high for exactly the cycles where the shown sample is at position `mark` (counted from 0) inside its segment, on every pass. It never rises if `mark` ≥ the effective length.
- R9: A table write (`cfg_we` with `cfg_sel`, `cfg_base`, `cfg_len`, `cfg_reps`, `cfg_mark`) replaces one entry. An entry that is already playing keeps the values it had when it was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Entry table write strobe |
| cfg_sel | input | IDX_W | Entry index to write |
| cfg_base | input | ADDR_W | Segment base address |
| cfg_len | input | LEN_W | Segment length in samples (0 = 1) |
| cfg_reps | input | LOOP_W | Repeat count (0 = 1) |
| cfg_mark | input | LEN_W | Marker sample offset within the segment |
| cnt_we | input | 1 | Active entry count write strobe |
| cnt_val | input | IDX_W+1 | Active entry count |
| trig | input | 1 | Trigger, sampled on each rising edge |
| rd_addr | output | ADDR_W | Sample memory read address |
| rd_data | input | DATA_W | Sample memory read data, same cycle |
| smp_out | output | DATA_W | Registered output sample |
| smp_valid | output | 1 | Output sample valid |
| marker | output | 1 | Marker pulse aligned with `smp_out` |

## Verification
Most wrong internal state shows on the sample port within one clock. Examples are a position or repeat counter that is off by one, a wrong entry index, or a wrong state after the last pass. The next output sample then differs from the memory word that a behavioural queue of expected samples predicts, or it keeps changing where it should freeze. A trigger that is wrongly accepted during streaming cuts the expected stream short in the very next cycle. A wrongly remembered trigger starts output one hold period early, so the compare flags it on the first cycle where a constant was expected. Errors in the marker offset or the entry count show as a marker or sample mismatch no later than the end of the affected pass.

// File: rtl/wave_seq_pkg.sv
package wave_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PLAY = 2'd1,
        S_HOLD = 2'd2,
        S_DONE = 2'd3
    } seq_state_e;

endpackage

// File: rtl/wave_step_table.sv
module wave_step_table #(
    parameter int ADDR_W    = 10,
    parameter int LEN_W     = 8,
    parameter int LOOP_W    = 4,
    parameter int MAX_STEPS = 16,
    parameter int IDX_W     = $clog2(MAX_STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [LOOP_W-1:0] cfg_reps,
    input  logic [LEN_W-1:0]  cfg_mark,
    input  logic              cnt_we,
    input  logic [IDX_W:0]    cnt_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] ent_base,
    output logic [LEN_W-1:0]  ent_len,
    output logic [LOOP_W-1:0] ent_reps,
    output logic [LEN_W-1:0]  ent_mark,
    output logic [IDX_W-1:0]  last_idx
);

    localparam logic [IDX_W:0] CNT_MAX = (IDX_W+1)'(MAX_STEPS);

    logic [ADDR_W-1:0] base_mem [MAX_STEPS];
    logic [LEN_W-1:0]  len_mem  [MAX_STEPS];
    logic [LOOP_W-1:0] reps_mem [MAX_STEPS];
    logic [LEN_W-1:0]  mark_mem [MAX_STEPS];
    logic [IDX_W:0]    cnt_q;
    logic [IDX_W:0]    cnt_m1;

    for (genvar g = 0; g < MAX_STEPS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_mem[g] <= '0;
                len_mem[g]  <= '0;
                reps_mem[g] <= '0;
                mark_mem[g] <= '0;
            end else if (cfg_we && cfg_sel == IDX_W'(g)) begin
                base_mem[g] <= cfg_base;
                len_mem[g]  <= cfg_len;
                reps_mem[g] <= cfg_reps;
                mark_mem[g] <= cfg_mark;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= (IDX_W+1)'(1);
        end else if (cnt_we) begin
            if (cnt_val == '0) begin
                cnt_q <= (IDX_W+1)'(1);
            end else if (cnt_val > CNT_MAX) begin
                cnt_q <= CNT_MAX;
            end else begin
                cnt_q <= cnt_val;
            end
        end
    end

    assign cnt_m1   = cnt_q - (IDX_W+1)'(1);
    assign last_idx = cnt_m1[IDX_W-1:0];
    assign ent_base = base_mem[rd_idx];
    assign ent_len  = len_mem[rd_idx];
    assign ent_reps = reps_mem[rd_idx];
    assign ent_mark = mark_mem[rd_idx];

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) && (cnt_q <= CNT_MAX));

endmodule

// File: rtl/wave_seq_ctrl.sv
module wave_seq_ctrl
    import wave_seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LEN_W  = 8,
    parameter int LOOP_W = 4,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [ADDR_W-1:0] ent_base,
    input  logic [LEN_W-1:0]  ent_len,
    input  logic [LOOP_W-1:0] ent_reps,
    input  logic [LEN_W-1:0]  ent_mark,
    input  logic [IDX_W-1:0]  last_idx,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sample_en,
    output logic              mark_hit
);

    seq_state_e        state_q, state_d;
    logic [IDX_W-1:0]  step_q;
    logic [LEN_W-1:0]  pos_q, len_last_q, mark_q;
    logic [LOOP_W-1:0] loop_q, reps_last_q;
    logic [ADDR_W-1:0] base_q, addr_q;
    logic              seg_end, run_end, load;

    assign seg_end = (pos_q == len_last_q);
    assign run_end = seg_end && (loop_q == reps_last_q);
    assign load    = trig && (state_q != S_PLAY);
    assign rd_idx  = (state_q == S_HOLD) ? step_q + IDX_W'(1) : '0;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (trig) state_d = S_PLAY;
            S_PLAY: if (run_end) state_d = (step_q >= last_idx) ? S_DONE : S_HOLD;
            S_HOLD: if (trig) state_d = S_PLAY;
            S_DONE: if (trig) state_d = S_PLAY;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // counters and latched entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q      <= '0;
            pos_q       <= '0;
            loop_q      <= '0;
            addr_q      <= '0;
            base_q      <= '0;
            len_last_q  <= '0;
            reps_last_q <= '0;
            mark_q      <= '0;
        end else if (load) begin
            step_q      <= rd_idx;
            pos_q       <= '0;
            loop_q      <= '0;
            addr_q      <= ent_base;
            base_q      <= ent_base;
            len_last_q  <= (ent_len == '0) ? '0 : ent_len - LEN_W'(1);
            reps_last_q <= (ent_reps == '0) ? '0 : ent_reps - LOOP_W'(1);
            mark_q      <= ent_mark;
        end else if (state_q == S_PLAY) begin
            if (seg_end) begin
                pos_q  <= '0;
                addr_q <= base_q;
                if (!run_end) loop_q <= loop_q + LOOP_W'(1);
            end else begin
                pos_q  <= pos_q + LEN_W'(1);
                addr_q <= addr_q + ADDR_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        sample_en = (state_q == S_PLAY);
        mark_hit  = (state_q == S_PLAY) && (pos_q == mark_q);
        rd_addr   = addr_q;
    end

    // R2
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PLAY) |-> (pos_q <= len_last_q) && (loop_q <= reps_last_q));

    // R6
    trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PLAY && !run_end) |=> (state_q == S_PLAY) && $stable(step_q) && $stable(base_q));

    // R5
    step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD && trig) |=> (state_q == S_PLAY) && (step_q == $past(step_q) + IDX_W'(1)));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE && trig) |=> (state_q == S_PLAY) && (step_q == '0));

endmodule

// File: rtl/wave_seq_out.sv
module wave_seq_out #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              mark_hit,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] smp_out,
    output logic              smp_valid,
    output logic              marker
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_out   <= '0;
            smp_valid <= 1'b0;
            marker    <= 1'b0;
        end else begin
            marker <= mark_hit;
            if (sample_en) begin
                smp_out   <= rd_data;
                smp_valid <= 1'b1;
            end
        end
    end

    // R1
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> smp_valid);

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !sample_en) |=> $stable(smp_out) && !marker);

    // R8
    marker_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        marker |-> smp_valid);

endmodule

// File: rtl/wave_step_seq.sv
module wave_step_seq #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 16,
    parameter int LEN_W     = 8,
    parameter int LOOP_W    = 4,
    parameter int MAX_STEPS = 16,
    localparam int IDX_W    = $clog2(MAX_STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [LOOP_W-1:0] cfg_reps,
    input  logic [LEN_W-1:0]  cfg_mark,
    input  logic              cnt_we,
    input  logic [IDX_W:0]    cnt_val,
    input  logic              trig,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] smp_out,
    output logic              smp_valid,
    output logic              marker
);

    logic [IDX_W-1:0]  rd_idx, last_idx;
    logic [ADDR_W-1:0] ent_base;
    logic [LEN_W-1:0]  ent_len, ent_mark;
    logic [LOOP_W-1:0] ent_reps;
    logic              sample_en, mark_hit;

    wave_step_table #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LOOP_W(LOOP_W),
        .MAX_STEPS(MAX_STEPS), .IDX_W(IDX_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
        .cfg_len(cfg_len), .cfg_reps(cfg_reps), .cfg_mark(cfg_mark),
        .cnt_we(cnt_we), .cnt_val(cnt_val), .rd_idx(rd_idx),
        .ent_base(ent_base), .ent_len(ent_len), .ent_reps(ent_reps),
        .ent_mark(ent_mark), .last_idx(last_idx)
    );

    wave_seq_ctrl #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LOOP_W(LOOP_W), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .trig(trig),
        .ent_base(ent_base), .ent_len(ent_len), .ent_reps(ent_reps),
        .ent_mark(ent_mark), .last_idx(last_idx), .rd_idx(rd_idx),
        .rd_addr(rd_addr), .sample_en(sample_en), .mark_hit(mark_hit)
    );

    wave_seq_out #(
        .DATA_W(DATA_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .mark_hit(mark_hit),
        .rd_data(rd_data), .smp_out(smp_out), .smp_valid(smp_valid), .marker(marker)
    );

endmodule

// File: tb/test_wave_step_seq.sv
module test_wave_step_seq;

    localparam int ADDR_W = 10, DATA_W = 16, LEN_W = 8, LOOP_W = 4, MAX_STEPS = 16;
    localparam int IDX_W = $clog2(MAX_STEPS);
    localparam int MEM_N = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [IDX_W-1:0]  cfg_sel = '0;
    logic [ADDR_W-1:0] cfg_base = '0;
    logic [LEN_W-1:0]  cfg_len = '0;
    logic [LOOP_W-1:0] cfg_reps = '0;
    logic [LEN_W-1:0]  cfg_mark = '0;
    logic              cnt_we = 1'b0;
    logic [IDX_W:0]    cnt_val = '0;
    logic              trig = 1'b0;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] smp_out;
    logic              smp_valid, marker;

    logic [DATA_W-1:0] mem [MEM_N];
    assign rd_data = mem[rd_addr];

    always #10 clk = ~clk;

    wave_step_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
        .LOOP_W(LOOP_W), .MAX_STEPS(MAX_STEPS)
    ) i_wave_step_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_reps(cfg_reps),
        .cfg_mark(cfg_mark), .cnt_we(cnt_we), .cnt_val(cnt_val), .trig(trig),
        .rd_addr(rd_addr), .rd_data(rd_data), .smp_out(smp_out),
        .smp_valid(smp_valid), .marker(marker)
    );

    int    n_vec = 0, n_bad = 0, cycles = 0;
    string cur_req = "R1";

    // behavioural reference
    int m_base [MAX_STEPS], m_len [MAX_STEPS], m_reps [MAX_STEPS], m_mark [MAX_STEPS];
    int m_cnt, next_step, cur_step;
    int q_smp[$];
    bit q_mk[$];
    bit exp_valid, exp_mark;
    int exp_smp;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_STEPS; i++) begin
                m_base[i] = 0; m_len[i] = 0; m_reps[i] = 0; m_mark[i] = 0;
            end
            m_cnt = 1; next_step = 0; cur_step = 0;
            q_smp.delete(); q_mk.delete();
            exp_valid = 0; exp_mark = 0; exp_smp = 0;
        end else begin
            automatic bit busy = (q_smp.size() > 0);
            if (busy) begin
                exp_smp   = q_smp.pop_front();
                exp_mark  = q_mk.pop_front();
                exp_valid = 1;
                if (q_smp.size() == 0)
                    next_step = (cur_step >= m_cnt - 1) ? 0 : cur_step + 1;
            end else begin
                exp_mark = 0;
            end
            if (!busy && trig) begin
                automatic int l = (m_len[next_step] == 0) ? 1 : m_len[next_step];
                automatic int r = (m_reps[next_step] == 0) ? 1 : m_reps[next_step];
                cur_step = next_step;
                for (int p = 0; p < r; p++)
                    for (int i = 0; i < l; i++) begin
                        q_smp.push_back(int'(mem[(m_base[cur_step] + i) % MEM_N]));
                        q_mk.push_back(i == m_mark[cur_step]);
                    end
            end
            if (cfg_we) begin
                m_base[cfg_sel] = int'(cfg_base); m_len[cfg_sel] = int'(cfg_len);
                m_reps[cfg_sel] = int'(cfg_reps); m_mark[cfg_sel] = int'(cfg_mark);
            end
            if (cnt_we) begin
                if (cnt_val == 0) m_cnt = 1;
                else if (int'(cnt_val) > MAX_STEPS) m_cnt = MAX_STEPS;
                else m_cnt = int'(cnt_val);
            end
        end
    end

    // per-cycle compare
    always @(negedge clk) begin
        if (rst_n) begin
            n_vec++;
            if (smp_valid !== exp_valid || marker !== exp_mark ||
                (exp_valid && int'(smp_out) != exp_smp)) begin
                n_bad++;
                $display("FAIL %s t=%0t valid %0b/%0b smp %h/%h marker %0b/%0b (actual/expected)",
                         cur_req, $time, smp_valid, exp_valid, smp_out, exp_smp[DATA_W-1:0],
                         marker, exp_mark);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse;
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
    endtask

    task automatic wr_step(input int idx, input int base, input int len, input int reps, input int mk);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = IDX_W'(idx); cfg_base = ADDR_W'(base);
        cfg_len = LEN_W'(len); cfg_reps = LOOP_W'(reps); cfg_mark = LEN_W'(mk);
        @(negedge clk) cfg_we = 1'b0;
    endtask

    task automatic wr_cnt(input int n);
        @(negedge clk) begin cnt_we = 1'b1; cnt_val = (IDX_W+1)'(n); end
        @(negedge clk) cnt_we = 1'b0;
    endtask

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d (actual) / limit 150000 (expected)", cycles);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < MEM_N; i++) mem[i] = DATA_W'((i * 73 + 5) ^ (i << 7));
        idle(3);
        // R1 reset state
        n_vec++;
        if (smp_valid !== 1'b0 || marker !== 1'b0 || smp_out !== '0) begin
            n_bad++;
            $display("FAIL R1 reset valid=%0b marker=%0b smp=%h (actual) / 0 0 0 (expected)",
                     smp_valid, marker, smp_out);
        end
        rst_n = 1'b1;

        cur_req = "R9";
        wr_step(0, 10, 5, 2, 3);
        wr_step(1, 100, 3, 0, 0);     // R3 zero repeats
        wr_step(2, 200, 0, 3, 0);     // R3 zero length
        wr_step(3, 1020, 6, 1, 9);    // R8 marker beyond length, R2 address wrap
        wr_cnt(4);
        cur_req = "R1"; idle(6);      // R1 no output before trigger

        cur_req = "R2"; pulse(); idle(3);
        cur_req = "R6"; pulse(); idle(3); pulse();  // R6 triggers during streaming
        cur_req = "R4"; idle(20);                    // R4 hold
        cur_req = "R5"; pulse(); idle(8);            // R5 step 1
        cur_req = "R3"; pulse(); idle(8);            // R3 step 2
        cur_req = "R8"; pulse(); idle(12);           // R8 step 3
        cur_req = "R7"; pulse(); idle(20);           // R7 restart at step 0

        cur_req = "R9"; pulse(); @(negedge clk);     // step 1 playing
        wr_step(1, 400, 7, 2, 6);                    // R9 must not affect the running pass
        idle(10);
        pulse(); idle(20);                           // step 2 (len 1, 3 reps)
        pulse(); idle(10);                           // step 3, list done
        pulse(); idle(15);                           // step 0
        pulse(); idle(20);                           // R9 new step 1 values

        cur_req = "R7"; idle(10);
        pulse(); idle(10); pulse(); idle(12);        // finish list
        wr_cnt(0);                                   // R7 0 taken as 1
        repeat (3) begin pulse(); idle(15); end

        for (int i = 4; i < MAX_STEPS; i++) wr_step(i, i * 53, (i % 5) + 1, i % 3, i % 4);
        wr_cnt(20);                                  // R7 clamp to MAX_STEPS

        cur_req = "R6";
        begin
            automatic int lfsr = 32'h1ACE5;
            for (int c = 0; c < 4000; c++) begin
                @(negedge clk);
                lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
                trig = ((lfsr & 3) == 0);
            end
            @(negedge clk) trig = 1'b0;
        end
        idle(40);
        finish_run();
    end

endmodule